// File: doc/BRIEF.md
# Memory Bandwidth Throttle Controller

This block decides when memory traffic has to be slowed down and how many commands each window may carry while it is. Four triggers can start throttling. Two are thermal trip levels, one from the controller and one from the memory rank. Two are activity counters: one counts write commands and one counts all commands, and both are compared against a shared threshold. Each trigger has its own programmable per-window command limit. The write-type triggers, which are the controller thermal trip and the write counter, limit only writes. The rank-type triggers, which are the rank thermal trip and the rank counter, limit reads and writes together.

A window is the interval between two pulses of the window tick. A new trigger selection is locked for the rest of the window in which it occurs and for the whole of the next window. Selection logic decides at each window boundary whether throttling continues, changes source or stops. The per-command allow outputs count granted commands within the current window and close once the limit in force is reached.

Top module: `mem_bw_throttle`

## Requirements
- R1: After reset the latched mode is 0000, throttle-active is 0, both allow outputs are 1 and the limit output is all ones.
- R2: The mode field is latched only on a cycle with the window tick high. Its bits, from bit 3 down to bit 0, enable the rank counter, the write counter, the rank thermal trip and the controller thermal trip.
- R3: With mode bit 0 set, a high controller thermal trip starts throttling of writes only, under the write-thermal limit. Reads stay allowed.
- R4: With mode bit 1 set, a high rank thermal trip starts throttling of both reads and writes under the rank-thermal limit.
- R5: With mode bit 2 set, write strobes are counted within a window, and the count is cleared at each tick. Once the count is at or above the threshold, write throttling starts under the write-counter limit.
- R6: With mode bit 3 set, read and write strobes are both counted within a window. Once that count is at or above the threshold, throttling starts under the rank-counter limit.
- R7: If the thermal trigger and the counter trigger of one kind trip in the same cycle, the thermal limit is chosen.
- R8: The limit chosen for a kind is held until the second window tick after the trip, even if the other trigger of that kind trips in the meantime.
- R9: At that second tick the kind selects again, with thermal first, from the triggers still tripped at that moment. If none is tripped it becomes idle, and throttle-active can only fall at a tick or after the mode becomes 0000.
- R10: While a limit applies, the allow outputs admit at most that many commands per window and reopen after the next tick. If a read and a write arrive in the same cycle, the read takes the slot first.
- R11: The limit output shows the rank-kind limit when the rank kind is active, otherwise the write-kind limit when the write kind is active, and otherwise all ones.
- R12: A trigger whose mode bit is clear has no effect. Its counter is held at zero, and a latched mode of 0000 clears any throttling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 4 | Trigger enables, latched at a window tick |
| ctl_hot_i | input | 1 | Controller thermal trip level |
| rank_hot_i | input | 1 | Rank thermal trip level |
| rd_req_i | input | 1 | Read command strobe |
| wr_req_i | input | 1 | Write command strobe |
| act_thresh_i | input | CNT_W | Shared activity threshold |
| lim_wr_hot_i | input | LIM_W | Write-thermal per-window limit |
| lim_rk_hot_i | input | LIM_W | Rank-thermal per-window limit |
| lim_wr_cnt_i | input | LIM_W | Write-counter per-window limit |
| lim_rk_cnt_i | input | LIM_W | Rank-counter per-window limit |
| win_tick_i | input | 1 | Window boundary pulse |
| thr_active_o | output | 1 | Throttling in force |
| lim_now_o | output | LIM_W | Limit currently in force |
| rd_allow_o | output | 1 | Read may be issued this cycle |
| wr_allow_o | output | 1 | Write may be issued this cycle |

## Verification
The case that is hardest to reach from the ports is the thermal and counter triggers of one kind tripping in exactly the same cycle. The counter trip only appears one edge after the last counted strobe. The stimulus therefore drives the threshold's worth of writes and raises the thermal level at the falling edge right after the final write, so that both are seen at one rising edge. The locked-source rule is reached by tripping the counter first, raising the thermal level inside the hold, and then stepping through both ticks to watch the reselection and the later drop.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_THERM = 2'd1,
    SRC_CNT   = 2'd2
  } src_e;

  localparam int unsigned KIND_WR  = 0;
  localparam int unsigned KIND_RK  = 1;
  localparam int unsigned NUM_KIND = 2;
  localparam int unsigned MODE_W   = 2 * NUM_KIND;
  localparam logic [1:0]  HOLD_WIN = 2'd2;

endpackage

// File: rtl/mbt_act_counter.sv
module mbt_act_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [1:0]       inc_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + {{(CNT_W-1){1'b0}}, inc_i};
    cnt_d = cnt_q;
    if (!en_i || tick_i) begin
      cnt_d = '0;
    end else if (sum[CNT_W]) begin
      cnt_d = '1;
    end else begin
      cnt_d = sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign hit_o = en_i && (cnt_q >= thresh_i);

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt_q == '0)); // R5
  AST_CNT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0)); // R12

endmodule

// File: rtl/mbt_kind_arb.sv
module mbt_kind_arb
  import mbt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic kill_i,
  input  logic therm_i,
  input  logic cnt_i,
  output src_e src_o,
  output logic active_o
);

  src_e       src_q, src_d;
  logic [1:0] hold_q, hold_d;

  always_comb begin
    src_d  = src_q;
    hold_d = hold_q;
    if (kill_i) begin
      src_d  = SRC_NONE;
      hold_d = 2'd0;
    end else if (src_q == SRC_NONE || (tick_i && hold_q <= 2'd1)) begin
      if (therm_i) begin
        src_d  = SRC_THERM;
        hold_d = HOLD_WIN;
      end else if (cnt_i) begin
        src_d  = SRC_CNT;
        hold_d = HOLD_WIN;
      end else begin
        src_d  = SRC_NONE;
        hold_d = 2'd0;
      end
    end else if (tick_i) begin
      hold_d = hold_q - 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= SRC_NONE;
      hold_q <= 2'd0;
    end else begin
      src_q  <= src_d;
      hold_q <= hold_d;
    end
  end

  assign src_o    = src_q;
  assign active_o = (src_q != SRC_NONE);

  AST_SRC_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q != SRC_NONE && !tick_i && !kill_i) |=> (src_q == $past(src_q))); // R8
  AST_THERM_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q == SRC_NONE && therm_i && !kill_i) |=> (src_q == SRC_THERM)); // R7
  AST_KILL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> (src_q == SRC_NONE)); // R12

endmodule

// File: rtl/mbt_grant_gate.sv
module mbt_grant_gate #(
  parameter int unsigned LIM_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rd_req_i,
  input  logic             wr_req_i,
  input  logic             rk_act_i,
  input  logic [LIM_W-1:0] rk_lim_i,
  input  logic             wr_act_i,
  input  logic [LIM_W-1:0] wr_lim_i,
  output logic             rd_allow_o,
  output logic             wr_allow_o
);

  localparam int unsigned GW = LIM_W + 1;

  logic [GW-1:0] all_q, all_d, wr_q, wr_d;
  logic [GW:0]   all_mid, all_sum, wr_sum;
  logic          rd_take, wr_take;

  always_comb begin
    rd_allow_o = !rk_act_i || (all_q < {1'b0, rk_lim_i});
    rd_take    = rd_req_i && rd_allow_o;
    all_mid    = {1'b0, all_q} + {{GW{1'b0}}, rd_take};
    wr_allow_o = (!rk_act_i || (all_mid < {2'b00, rk_lim_i})) &&
                 (!wr_act_i || (wr_q < {1'b0, wr_lim_i}));
    wr_take    = wr_req_i && wr_allow_o;
    all_sum    = all_mid + {{GW{1'b0}}, wr_take};
    wr_sum     = {1'b0, wr_q} + {{GW{1'b0}}, wr_take};
    if (tick_i) begin
      all_d = '0;
      wr_d  = '0;
    end else begin
      all_d = all_sum[GW] ? '1 : all_sum[GW-1:0];
      wr_d  = wr_sum[GW]  ? '1 : wr_sum[GW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      all_q <= '0;
      wr_q  <= '0;
    end else begin
      all_q <= all_d;
      wr_q  <= wr_d;
    end
  end

  AST_RK_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rk_act_i && !tick_i && all_q >= {1'b0, rk_lim_i}) |=> (all_q == $past(all_q))); // R10
  AST_WR_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_act_i && !tick_i && wr_q >= {1'b0, wr_lim_i}) |=> (wr_q == $past(wr_q))); // R3
  AST_TICK_REOPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (all_q == '0 && wr_q == '0)); // R10

endmodule

// File: rtl/mem_bw_throttle.sv
module mem_bw_throttle
  import mbt_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned LIM_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              ctl_hot_i,
  input  logic              rank_hot_i,
  input  logic              rd_req_i,
  input  logic              wr_req_i,
  input  logic [CNT_W-1:0]  act_thresh_i,
  input  logic [LIM_W-1:0]  lim_wr_hot_i,
  input  logic [LIM_W-1:0]  lim_rk_hot_i,
  input  logic [LIM_W-1:0]  lim_wr_cnt_i,
  input  logic [LIM_W-1:0]  lim_rk_cnt_i,
  input  logic              win_tick_i,
  output logic              thr_active_o,
  output logic [LIM_W-1:0]  lim_now_o,
  output logic              rd_allow_o,
  output logic              wr_allow_o
);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  // mode latch, enabled by the window tick
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              kill;

  always_comb begin
    mode_d = mode_q;
    if (win_tick_i) begin
      mode_d = mode_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign kill = (mode_q == '0);

  // per-kind trigger inputs and limits
  logic [NUM_KIND-1:0] hot_in, hot_raw, cnt_hit, k_act;
  logic [1:0]          k_inc   [NUM_KIND];
  logic [LIM_W-1:0]    hot_lim [NUM_KIND];
  logic [LIM_W-1:0]    cnt_lim [NUM_KIND];
  logic [LIM_W-1:0]    k_lim   [NUM_KIND];
  src_e                k_src   [NUM_KIND];

  always_comb begin
    hot_in[KIND_WR]  = ctl_hot_i;
    hot_in[KIND_RK]  = rank_hot_i;
    k_inc[KIND_WR]   = {1'b0, wr_req_i};
    k_inc[KIND_RK]   = {1'b0, rd_req_i} + {1'b0, wr_req_i};
    hot_lim[KIND_WR] = lim_wr_hot_i;
    hot_lim[KIND_RK] = lim_rk_hot_i;
    cnt_lim[KIND_WR] = lim_wr_cnt_i;
    cnt_lim[KIND_RK] = lim_rk_cnt_i;
  end

  for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
    assign hot_raw[k] = mode_q[k] & hot_in[k];

    mbt_act_counter #(
      .CNT_W (CNT_W)
    ) act_cnt_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_n),
      .en_i     (mode_q[k + NUM_KIND]),
      .tick_i   (win_tick_i),
      .inc_i    (k_inc[k]),
      .thresh_i (act_thresh_i),
      .hit_o    (cnt_hit[k])
    );

    mbt_kind_arb arb_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_n),
      .tick_i   (win_tick_i),
      .kill_i   (kill),
      .therm_i  (hot_raw[k]),
      .cnt_i    (cnt_hit[k]),
      .src_o    (k_src[k]),
      .active_o (k_act[k])
    );

    assign k_lim[k] = (k_src[k] == SRC_THERM) ? hot_lim[k] : cnt_lim[k];
  end

  // outputs
  always_comb begin
    thr_active_o = |k_act;
    if (k_act[KIND_RK]) begin
      lim_now_o = k_lim[KIND_RK];
    end else if (k_act[KIND_WR]) begin
      lim_now_o = k_lim[KIND_WR];
    end else begin
      lim_now_o = '1;
    end
  end

  mbt_grant_gate #(
    .LIM_W (LIM_W)
  ) gate_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .tick_i     (win_tick_i),
    .rd_req_i   (rd_req_i),
    .wr_req_i   (wr_req_i),
    .rk_act_i   (k_act[KIND_RK]),
    .rk_lim_i   (k_lim[KIND_RK]),
    .wr_act_i   (k_act[KIND_WR]),
    .wr_lim_i   (k_lim[KIND_WR]),
    .rd_allow_o (rd_allow_o),
    .wr_allow_o (wr_allow_o)
  );

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    !win_tick_i |=> $stable(mode_q)); // R2
  AST_DROP_EDGE: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(thr_active_o) |-> ($past(win_tick_i) || $past(mode_q) == '0)); // R9
  AST_IDLE_OPEN: assert property (@(posedge clk_i) disable iff (!rst_n)
    !thr_active_o |-> (rd_allow_o && wr_allow_o)); // R10

endmodule

// File: tb/mem_bw_throttle_tb.sv
module mem_bw_throttle_tb_top;

  localparam int unsigned CNT_W = 8;
  localparam int unsigned LIM_W = 6;
  localparam logic [LIM_W-1:0] OPEN = '1;

  logic             clk;
  logic             rst_n;
  logic [3:0]       mode;
  logic             ctl_hot, rank_hot, rd_req, wr_req, tick;
  logic [CNT_W-1:0] thresh;
  logic [LIM_W-1:0] l_wh, l_rh, l_wc, l_rc;
  logic             thr_act, rd_ok, wr_ok;
  logic [LIM_W-1:0] lim_now;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  mem_bw_throttle #(.CNT_W(CNT_W), .LIM_W(LIM_W)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mode_i       (mode),
    .ctl_hot_i    (ctl_hot),
    .rank_hot_i   (rank_hot),
    .rd_req_i     (rd_req),
    .wr_req_i     (wr_req),
    .act_thresh_i (thresh),
    .lim_wr_hot_i (l_wh),
    .lim_rk_hot_i (l_rh),
    .lim_wr_cnt_i (l_wc),
    .lim_rk_cnt_i (l_rc),
    .win_tick_i   (tick),
    .thr_active_o (thr_act),
    .lim_now_o    (lim_now),
    .rd_allow_o   (rd_ok),
    .wr_allow_o   (wr_ok)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // entry: mode[18:15] ctl[14] rank[13] nwr[12:10] nrd[9:7] act[6] lim[5:0]
  localparam int NV = 12;
  localparam logic [18:0] TBL [NV] = '{
    {4'b0000, 1'b1, 1'b1, 3'd5, 3'd5, 1'b0, 6'd63}, // R12 all off
    {4'b0001, 1'b1, 1'b0, 3'd0, 3'd0, 1'b1, 6'd5},  // R3
    {4'b0001, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0, 6'd63}, // R12 rank trip not enabled
    {4'b0010, 1'b0, 1'b1, 3'd0, 3'd0, 1'b1, 6'd7},  // R4
    {4'b0100, 1'b0, 1'b0, 3'd4, 3'd0, 1'b1, 6'd9},  // R5
    {4'b0100, 1'b0, 1'b0, 3'd3, 3'd0, 1'b0, 6'd63}, // R5 below threshold
    {4'b1000, 1'b0, 1'b0, 3'd2, 3'd2, 1'b1, 6'd11}, // R6
    {4'b0011, 1'b1, 1'b1, 3'd0, 3'd0, 1'b1, 6'd7},  // R11 rank over write
    {4'b0101, 1'b1, 1'b0, 3'd4, 3'd0, 1'b1, 6'd5},  // R8 thermal first
    {4'b1100, 1'b0, 1'b0, 3'd4, 3'd0, 1'b1, 6'd11}, // R11 both counters
    {4'b0100, 1'b0, 1'b0, 3'd0, 3'd5, 1'b0, 6'd63}, // R5 reads not counted
    {4'b1010, 1'b0, 1'b1, 3'd0, 3'd4, 1'b1, 6'd7}   // R8 rank thermal first
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mode = '0; ctl_hot = 0; rank_hot = 0; rd_req = 0; wr_req = 0; tick = 0;
    thresh = 8'd4; l_wh = 6'd5; l_rh = 6'd7; l_wc = 6'd9; l_rc = 6'd11;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic load_mode(input logic [3:0] m);
    mode = m;
    pulse_tick();
  endtask

  task automatic wr_n(input int n);
    for (int i = 0; i < n; i++) begin
      wr_req = 1'b1;
      @(negedge clk);
    end
    wr_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1 actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 thr_active", thr_act, 0);
    chk("R1 rd_allow", rd_ok, 1);
    chk("R1 wr_allow", wr_ok, 1);
    chk("R1 lim_now", lim_now, OPEN);

    // table walk
    for (int v = 0; v < NV; v++) begin
      do_reset();
      load_mode(TBL[v][18:15]);
      ctl_hot  = TBL[v][14];
      rank_hot = TBL[v][13];
      wr_n(int'(TBL[v][12:10]));
      for (int i = 0; i < int'(TBL[v][9:7]); i++) begin
        rd_req = 1'b1;
        @(negedge clk);
      end
      rd_req = 1'b0;
      repeat (2) @(negedge clk);
      chk($sformatf("R11 table %0d active", v), thr_act, TBL[v][6]);
      chk($sformatf("R11 table %0d limit", v), lim_now, TBL[v][5:0]);
    end

    // R2 mode takes effect only at a tick
    do_reset();
    mode = 4'b0001; ctl_hot = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 no tick yet", thr_act, 0);
    pulse_tick();
    @(negedge clk);
    chk("R2 after tick", thr_act, 1);
    chk("R2 limit", lim_now, 5);

    // R3 write-only gating under write-thermal limit 2
    do_reset();
    l_wh = 6'd2;
    load_mode(4'b0001);
    ctl_hot = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      wr_req = 1'b1; #1;
      chk("R3 write granted", wr_ok, 1);
      @(negedge clk);
    end
    wr_req = 1'b1; #1;
    chk("R3 write blocked", wr_ok, 0);
    wr_req = 1'b0; rd_req = 1'b1; #1;
    chk("R3 read open", rd_ok, 1);
    rd_req = 1'b0;

    // R12 latched mode 0000 clears throttling
    load_mode(4'b0000);
    @(negedge clk);
    chk("R12 mode zero clears", thr_act, 0);
    chk("R12 limit open", lim_now, OPEN);

    // R5 counts do not carry across windows
    do_reset();
    load_mode(4'b0100);
    wr_n(2);
    pulse_tick();
    wr_n(2);
    repeat (2) @(negedge clk);
    chk("R5 count cleared at tick", thr_act, 0);

    // R7 thermal and counter trip in the same cycle
    do_reset();
    thresh = 8'd2;
    load_mode(4'b0101);
    wr_n(2);
    ctl_hot = 1'b1;
    @(negedge clk);
    chk("R7 simultaneous active", thr_act, 1);
    chk("R7 thermal wins", lim_now, 5);

    // R8 / R9 lock, reselection and drop
    do_reset();
    thresh = 8'd2;
    load_mode(4'b0101);
    wr_n(2);
    @(negedge clk);
    chk("R8 counter limit", lim_now, 9);
    ctl_hot = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 locked in window", lim_now, 9);
    pulse_tick();
    chk("R8 locked after first tick", lim_now, 9);
    pulse_tick();
    chk("R9 reselect thermal", lim_now, 5);
    ctl_hot = 1'b0;
    pulse_tick();
    chk("R9 held first tick", thr_act, 1);
    pulse_tick();
    chk("R9 dropped", thr_act, 0);
    chk("R9 limit open", lim_now, OPEN);

    // R10 per-window cap with read precedence
    do_reset();
    l_rh = 6'd3;
    load_mode(4'b0010);
    rank_hot = 1'b1;
    @(negedge clk);
    chk("R4 rank limit", lim_now, 3);
    for (int i = 0; i < 2; i++) begin
      rd_req = 1'b1; #1;
      chk("R10 read granted", rd_ok, 1);
      @(negedge clk);
    end
    rd_req = 1'b1; wr_req = 1'b1; #1;
    chk("R10 read takes last slot", rd_ok, 1);
    chk("R10 write loses last slot", wr_ok, 0);
    @(negedge clk);
    wr_req = 1'b0; #1;
    chk("R10 read blocked", rd_ok, 0);
    rd_req = 1'b0;
    pulse_tick();
    rd_req = 1'b1; #1;
    chk("R10 reopened after tick", rd_ok, 1);
    rd_req = 1'b0;
    @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule